// File: doc/BRIEF.md
# Redundant Reference Clock Switchover Controller

The block picks one of two reference clocks and passes it to a downstream clock consumer. Its clock output never carries a shortened pulse. A free-running monitor clock watches both references. Each reference has its own "lost" flag, raised when that reference stops toggling. A mode input selects one of three policies:
- automatic failover,
- switching on an active-low external request,
- automatic failover that the external request can override.

A manual switch fires on a falling edge of the request. The request must then stay low for a set number of cycles of the reference being switched to, so short noise pulses on the request line are rejected. When the request is held low in combined mode, it freezes the current selection.

Top module: `refclk_switchover`

## Requirements
- R1: While reset is asserted and right after it, `sel_out` is 0 and both lost flags are 0. Once reset is released, `clk_out` carries reference 0.
- R2: A reference's lost flag rises when no rising edge of that reference is seen within LOSS_WINDOW monitor cycles (default 16). The flag falls again once edges come back.
- R3: With `mode` = 2'b00 (automatic), loss of the active reference while the other one is running switches the selection to the other one.
- R4: In automatic mode, no switch is made while the alternate reference is itself flagged lost.
- R5: With `mode` = 2'b01 (manual; 2'b11 behaves the same), a high-to-low transition of `sw_req_n` causes exactly one switch if the request stays low for at least HOLD_CYCLES (default 3) rising edges of the non-active reference. A low level that has not been preceded by a high level since reset causes no switch.
- R6: A low pulse on `sw_req_n` that is shorter than HOLD_CYCLES cycles of the non-active reference causes no switch.
- R7: In manual mode, loss of the active reference does not by itself cause a switch.
- R8: With `mode` = 2'b10 (combined), automatic failover works while `sw_req_n` is high, and a qualified manual request also switches.
- R9: In combined mode, while `sw_req_n` stays low, no further switch of any kind happens, even if the active reference is lost. Automatic failover resumes once the request returns high.
- R10: The handover between references works as follows:
  - The old reference is gated off on its own falling edge, or at once if it is flagged lost.
  - The new reference is gated on after two of its own falling edges.
  - No pulse on `clk_out` is shorter than half a period of either reference.
  - `sel_out` changes only when the handover is complete.
- R11: In automatic mode, `sw_req_n` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_mon | input | 1 | Free-running monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ref0 | input | 1 | Reference clock 0 |
| clk_ref1 | input | 1 | Reference clock 1 |
| sw_req_n | input | 1 | Active-low external switch request |
| mode | input | 2 | 00 automatic, 01 manual, 10 combined, 11 manual |
| clk_out | output | 1 | Selected reference, glitch-free |
| sel_out | output | 1 | Index of the active reference |
| lost0 | output | 1 | Reference 0 flagged as stopped |
| lost1 | output | 1 | Reference 1 flagged as stopped |

## Verification
A wrong internal state usually shows on `sel_out` within a few tens of monitor cycles:
- A stuck or early-firing loss counter shows as a lost flag that disagrees with the stimulus one window later.
- A hold counter that is off by one turns the two-cycle request pulse into a switch.
- A lost override latch lets the selection move while the request is still low.

A mux enable chain that is broken appears as a gap or a runt on `clk_out`. It also appears as a handover that never completes, leaving `sel_out` frozen. For that reason, the pulse widths of the output clock are watched for the whole run.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;
  localparam int unsigned NUM_REFS = 2;

  typedef enum logic [1:0] {
    MODE_AUTO      = 2'b00,
    MODE_MANUAL    = 2'b01,
    MODE_COMBINED  = 2'b10,
    MODE_MANUAL_B  = 2'b11
  } sw_mode_e;

  typedef enum logic {
    ST_RUN      = 1'b0,
    ST_HANDOVER = 1'b1
  } sw_state_e;
endpackage

// File: rtl/clksw_rst_sync.sv
`timescale 1ns/1ps
module clksw_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] pipe_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= 2'b00;
    else         pipe_q <= {pipe_q[0], 1'b1};
  end

  assign srst_n = pipe_q[1];
endmodule

// File: rtl/clksw_loss_det.sv
`timescale 1ns/1ps
module clksw_loss_det #(
  parameter int unsigned WINDOW = 16
) (
  input  logic clk_ref,
  input  logic rst_ref_n,
  input  logic clk_mon,
  input  logic rst_mon_n,
  output logic lost
);
  localparam int unsigned CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

  // reference domain: one toggle per rising edge
  logic tgl_q;
  always_ff @(posedge clk_ref or negedge rst_ref_n) begin
    if (!rst_ref_n) tgl_q <= 1'b0;
    else            tgl_q <= ~tgl_q;
  end

  // monitor domain
  logic [2:0]    sync_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          lost_q, lost_d;
  logic          edge_seen;

  assign edge_seen = sync_q[2] ^ sync_q[1];

  always_comb begin
    cnt_d  = cnt_q;
    lost_d = lost_q;
    if (edge_seen) begin
      cnt_d  = '0;
      lost_d = 1'b0;
    end else if (cnt_q == LAST) begin
      lost_d = 1'b1;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_mon or negedge rst_mon_n) begin
    if (!rst_mon_n) begin
      sync_q <= 3'b000;
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], tgl_q};
      cnt_q  <= cnt_d;
      lost_q <= lost_d;
    end
  end

  assign lost = lost_q;

  p_edge_clears_lost_r2: assert property (@(posedge clk_mon) disable iff (!rst_mon_n)
    edge_seen |=> !lost_q);
endmodule

// File: rtl/clksw_req_qual.sv
`timescale 1ns/1ps
module clksw_req_qual #(
  parameter int unsigned HOLD = 3
) (
  input  logic clk_ref,
  input  logic rst_ref_n,
  input  logic req_n,
  output logic qual_tgl
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] FIRE = CW'(HOLD - 1);
  localparam logic [CW-1:0] TOP  = CW'(HOLD);

  logic [1:0]    sync_q;
  logic          req_s;
  logic          seen_hi_q, seen_hi_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          tgl_q, tgl_d;

  assign req_s = sync_q[1];

  always_comb begin
    seen_hi_d = seen_hi_q;
    cnt_d     = cnt_q;
    tgl_d     = tgl_q;
    if (req_s) begin
      cnt_d     = '0;
      seen_hi_d = 1'b1;
    end else if (seen_hi_q && (cnt_q != TOP)) begin
      cnt_d = cnt_q + CW'(1);
      if (cnt_q == FIRE) tgl_d = ~tgl_q;
    end
  end

  always_ff @(posedge clk_ref or negedge rst_ref_n) begin
    if (!rst_ref_n) begin
      sync_q    <= 2'b00;
      seen_hi_q <= 1'b0;
      cnt_q     <= '0;
      tgl_q     <= 1'b0;
    end else begin
      sync_q    <= {sync_q[0], req_n};
      seen_hi_q <= seen_hi_d;
      cnt_q     <= cnt_d;
      tgl_q     <= tgl_d;
    end
  end

  assign qual_tgl = tgl_q;

  p_fire_needs_low_r5: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
    !$stable(tgl_q) |-> !$past(req_s));
endmodule

// File: rtl/clksw_glitchless_mux.sv
`timescale 1ns/1ps
module clksw_glitchless_mux
  import clksw_pkg::*;
(
  input  logic [NUM_REFS-1:0] clk_in,
  input  logic [NUM_REFS-1:0] arst_n,
  input  logic                want_sel,
  output logic [NUM_REFS-1:0] en,
  output logic                clk_out
);
  generate
    for (genvar g = 0; g < NUM_REFS; g++) begin : g_chain
      localparam logic MINE = (g == 1);
      logic stage_q, en_q;
      always_ff @(negedge clk_in[g] or negedge arst_n[g]) begin
        if (!arst_n[g]) begin
          stage_q <= 1'b0;
          en_q    <= 1'b0;
        end else begin
          stage_q <= (want_sel == MINE) & ~en[NUM_REFS-1-g];
          en_q    <= stage_q;
        end
      end
      assign en[g] = en_q;
    end
  endgenerate

  assign clk_out = |(clk_in & en);

  always_comb begin
    p_one_clock_enabled_r10: assert ($onehot0(en));
  end
endmodule

// File: rtl/clksw_ctrl.sv
`timescale 1ns/1ps
module clksw_ctrl
  import clksw_pkg::*;
(
  input  logic                clk_mon,
  input  logic                rst_mon_n,
  input  logic [NUM_REFS-1:0] lost,
  input  logic [NUM_REFS-1:0] qual_tgl,
  input  logic                req_n,
  input  logic [1:0]          mode,
  input  logic [NUM_REFS-1:0] en,
  output logic                want_sel,
  output logic                cur_sel,
  output logic [NUM_REFS-1:0] kill
);
  // synchronizers into the monitor domain
  logic [1:0]          req_pipe_q;
  logic [1:0]          mode_p1_q, mode_p2_q;
  logic [NUM_REFS-1:0] qual_evt, en_seen;

  always_ff @(posedge clk_mon or negedge rst_mon_n) begin
    if (!rst_mon_n) begin
      req_pipe_q <= 2'b11;
      mode_p1_q  <= 2'b00;
      mode_p2_q  <= 2'b00;
    end else begin
      req_pipe_q <= {req_pipe_q[0], req_n};
      mode_p1_q  <= mode;
      mode_p2_q  <= mode_p1_q;
    end
  end

  generate
    for (genvar g = 0; g < NUM_REFS; g++) begin : g_sync
      logic [2:0] qual_q;
      logic [1:0] en_q;
      always_ff @(posedge clk_mon or negedge rst_mon_n) begin
        if (!rst_mon_n) begin
          qual_q <= 3'b000;
          en_q   <= 2'b00;
        end else begin
          qual_q <= {qual_q[1:0], qual_tgl[g]};
          en_q   <= {en_q[0], en[g]};
        end
      end
      assign qual_evt[g] = qual_q[2] ^ qual_q[1];
      assign en_seen[g]  = en_q[1];
    end
  endgenerate

  sw_mode_e  mode_q;
  sw_state_e state_q, state_d;
  logic      want_q, want_d, cur_q, cur_d, block_q, block_d;
  logic [NUM_REFS-1:0] kill_q, kill_d;
  logic      req_hi, is_auto, is_comb, auto_en, tgt, man_go, auto_go;

  assign mode_q  = sw_mode_e'(mode_p2_q);
  assign req_hi  = req_pipe_q[1];
  assign is_auto = (mode_q == MODE_AUTO);
  assign is_comb = (mode_q == MODE_COMBINED);
  assign auto_en = is_auto || (is_comb && req_hi);
  assign tgt     = ~cur_q;
  assign man_go  = !is_auto && !block_q && qual_evt[tgt];
  assign auto_go = auto_en && lost[cur_q] && !lost[tgt];

  always_comb begin
    state_d = state_q;
    want_d  = want_q;
    cur_d   = cur_q;
    block_d = block_q;
    case (state_q)
      ST_RUN: begin
        if (man_go || auto_go) begin
          want_d  = tgt;
          state_d = ST_HANDOVER;
          if (man_go) block_d = 1'b1;
        end
      end
      ST_HANDOVER: begin
        if (en_seen[want_q] && !en_seen[~want_q]) begin
          cur_d   = want_q;
          state_d = ST_RUN;
        end
      end
      default: state_d = ST_RUN;
    endcase
    if (req_hi) block_d = 1'b0;
    for (int k = 0; k < NUM_REFS; k++) begin
      kill_d[k] = (state_d == ST_HANDOVER) && (want_d != k[0]) && lost[k];
    end
  end

  always_ff @(posedge clk_mon or negedge rst_mon_n) begin
    if (!rst_mon_n) begin
      state_q <= ST_RUN;
      want_q  <= 1'b0;
      cur_q   <= 1'b0;
      block_q <= 1'b0;
      kill_q  <= '0;
    end else begin
      state_q <= state_d;
      want_q  <= want_d;
      cur_q   <= cur_d;
      block_q <= block_d;
      kill_q  <= kill_d;
    end
  end

  assign want_sel = want_q;
  assign cur_sel  = cur_q;
  assign kill     = kill_q;

  p_sel_at_handover_r10: assert property (@(posedge clk_mon) disable iff (!rst_mon_n)
    !$stable(cur_q) |-> $past(state_q) == ST_HANDOVER);

  p_auto_skips_lost_r4: assert property (@(posedge clk_mon) disable iff (!rst_mon_n)
    (state_q == ST_RUN && is_auto && lost[tgt]) |=> state_q == ST_RUN);

  p_manual_ignores_loss_r7: assert property (@(posedge clk_mon) disable iff (!rst_mon_n)
    (state_q == ST_RUN && mode_q == MODE_MANUAL && !qual_evt[tgt]) |=> state_q == ST_RUN);

  p_override_holds_r9: assert property (@(posedge clk_mon) disable iff (!rst_mon_n)
    (state_q == ST_RUN && is_comb && !req_hi && block_q) |=> state_q == ST_RUN);
endmodule

// File: rtl/refclk_switchover.sv
`timescale 1ns/1ps
module refclk_switchover
  import clksw_pkg::*;
#(
  parameter int unsigned LOSS_WINDOW = 16,
  parameter int unsigned HOLD_CYCLES = 3
) (
  input  logic       clk_mon,
  input  logic       rst_n,
  input  logic       clk_ref0,
  input  logic       clk_ref1,
  input  logic       sw_req_n,
  input  logic [1:0] mode,
  output logic       clk_out,
  output logic       sel_out,
  output logic       lost0,
  output logic       lost1
);
  logic [NUM_REFS-1:0] clk_in, rst_ref_n, lost, qual_tgl, kill, en, chain_arst_n;
  logic rst_mon_n, want_sel, cur_sel;

  assign clk_in = {clk_ref1, clk_ref0};

  clksw_rst_sync u_rst_mon (.clk(clk_mon), .arst_n(rst_n), .srst_n(rst_mon_n));

  generate
    for (genvar g = 0; g < NUM_REFS; g++) begin : g_ref
      clksw_rst_sync u_rst (.clk(clk_in[g]), .arst_n(rst_n), .srst_n(rst_ref_n[g]));

      clksw_loss_det #(.WINDOW(LOSS_WINDOW)) u_loss (
        .clk_ref  (clk_in[g]),
        .rst_ref_n(rst_ref_n[g]),
        .clk_mon  (clk_mon),
        .rst_mon_n(rst_mon_n),
        .lost     (lost[g])
      );

      clksw_req_qual #(.HOLD(HOLD_CYCLES)) u_qual (
        .clk_ref  (clk_in[g]),
        .rst_ref_n(rst_ref_n[g]),
        .req_n    (sw_req_n),
        .qual_tgl (qual_tgl[g])
      );

      assign chain_arst_n[g] = rst_ref_n[g] & ~kill[g];
    end
  endgenerate

  clksw_ctrl u_ctrl (
    .clk_mon  (clk_mon),
    .rst_mon_n(rst_mon_n),
    .lost     (lost),
    .qual_tgl (qual_tgl),
    .req_n    (sw_req_n),
    .mode     (mode),
    .en       (en),
    .want_sel (want_sel),
    .cur_sel  (cur_sel),
    .kill     (kill)
  );

  clksw_glitchless_mux u_mux (
    .clk_in  (clk_in),
    .arst_n  (chain_arst_n),
    .want_sel(want_sel),
    .en      (en),
    .clk_out (clk_out)
  );

  assign sel_out = cur_sel;
  assign lost0   = lost[0];
  assign lost1   = lost[1];
endmodule

// File: tb/refclk_switchover_tb_top.sv
`timescale 1ns/1ps
module refclk_switchover_tb_top;
  logic       clk_mon = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_ref0 = 1'b0;
  logic       clk_ref1 = 1'b0;
  logic       sw_req_n = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       clk_out, sel_out, lost0, lost1;
  bit         run0 = 1'b1;
  bit         run1 = 1'b1;
  int         total = 0;
  int         bad = 0;
  int         runts = 0;
  int         out_edges = 0;
  realtime    t_edge = 0.0;

  refclk_switchover dut_i (
    .clk_mon (clk_mon),
    .rst_n   (rst_n),
    .clk_ref0(clk_ref0),
    .clk_ref1(clk_ref1),
    .sw_req_n(sw_req_n),
    .mode    (mode),
    .clk_out (clk_out),
    .sel_out (sel_out),
    .lost0   (lost0),
    .lost1   (lost1)
  );

  always #10 clk_mon = ~clk_mon;  // 50 MHz

  initial forever begin
    if (run0) begin #30 clk_ref0 = 1'b1; #30 clk_ref0 = 1'b0; end
    else #10;
  end

  initial forever begin
    if (run1) begin #40 clk_ref1 = 1'b1; #40 clk_ref1 = 1'b0; end
    else #10;
  end

  // R10: pulse-width watch on the output clock
  always @(clk_out) begin
    if (t_edge != 0.0 && ($realtime - t_edge) < 25.0) runts++;
    t_edge = $realtime;
  end

  always @(posedge clk_out) out_edges++;

  task automatic check(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_mon(int n);
    repeat (n) @(posedge clk_mon);
  endtask

  task automatic drive_low(bit tgt);
    if (tgt) @(negedge clk_ref1); else @(negedge clk_ref0);
    sw_req_n = 1'b0;
  endtask

  task automatic pulse(int n, bit tgt);
    drive_low(tgt);
    repeat (n) begin
      if (tgt) @(posedge clk_ref1); else @(posedge clk_ref0);
    end
    if (tgt) @(negedge clk_ref1); else @(negedge clk_ref0);
    sw_req_n = 1'b1;
  endtask

  localparam logic [2:0] A_MODE = 3'd0, A_STOP = 3'd1, A_START = 3'd2,
                         A_PULSE = 3'd3, A_LOW = 3'd4, A_HIGH = 3'd5;
  localparam int NV = 23;
  // {req, action, arg, exp sel, exp lost0, exp lost1}
  localparam logic [11:0] VEC [NV] = '{
    {4'd11, A_MODE,  2'd0, 1'b0, 1'b0, 1'b0},  // R11 automatic mode
    {4'd11, A_PULSE, 2'd3, 1'b0, 1'b0, 1'b0},  // R11 request ignored
    {4'd3,  A_STOP,  2'd0, 1'b1, 1'b1, 1'b0},  // R3 failover to 1
    {4'd2,  A_START, 2'd0, 1'b1, 1'b0, 1'b0},  // R2 flag clears
    {4'd3,  A_STOP,  2'd1, 1'b0, 1'b0, 1'b1},  // R3 failover to 0
    {4'd2,  A_START, 2'd1, 1'b0, 1'b0, 1'b0},  // R2
    {4'd2,  A_STOP,  2'd1, 1'b0, 1'b0, 1'b1},  // R2 idle input flagged
    {4'd4,  A_STOP,  2'd0, 1'b0, 1'b1, 1'b1},  // R4 no switch to lost input
    {4'd2,  A_START, 2'd0, 1'b0, 1'b0, 1'b1},  // R2
    {4'd2,  A_START, 2'd1, 1'b0, 1'b0, 1'b0},  // R2
    {4'd6,  A_MODE,  2'd1, 1'b0, 1'b0, 1'b0},  // R6 manual mode
    {4'd6,  A_PULSE, 2'd2, 1'b0, 1'b0, 1'b0},  // R6 two cycles: no switch
    {4'd5,  A_PULSE, 2'd3, 1'b1, 1'b0, 1'b0},  // R5 three cycles: switch
    {4'd5,  A_PULSE, 2'd3, 1'b0, 1'b0, 1'b0},  // R5 and back
    {4'd7,  A_STOP,  2'd0, 1'b0, 1'b1, 1'b0},  // R7 manual ignores loss
    {4'd7,  A_START, 2'd0, 1'b0, 1'b0, 1'b0},  // R7
    {4'd8,  A_MODE,  2'd2, 1'b0, 1'b0, 1'b0},  // R8 combined mode
    {4'd8,  A_STOP,  2'd0, 1'b1, 1'b1, 1'b0},  // R8 auto failover
    {4'd8,  A_START, 2'd0, 1'b1, 1'b0, 1'b0},  // R8
    {4'd8,  A_LOW,   2'd0, 1'b0, 1'b0, 1'b0},  // R8 manual switch in combined
    {4'd9,  A_STOP,  2'd0, 1'b0, 1'b1, 1'b0},  // R9 override holds
    {4'd9,  A_HIGH,  2'd0, 1'b1, 1'b1, 1'b0},  // R9 release resumes auto
    {4'd9,  A_START, 2'd0, 1'b1, 1'b0, 1'b0}   // R9
  };

  initial begin
    bit cur_exp;
    cur_exp = 1'b0;
    rst_n = 1'b0;
    wait_mon(5);
    @(negedge clk_mon);
    check("R1", sel_out, 0);
    check("R1", lost0, 0);
    check("R1", lost1, 0);
    rst_n = 1'b1;
    wait_mon(100);

    for (int i = 0; i < NV; i++) begin
      logic [11:0] v;
      v = VEC[i];
      case (v[7:5])
        A_MODE:  mode = v[4:3];
        A_STOP:  if (v[3]) run1 = 1'b0; else run0 = 1'b0;
        A_START: if (v[3]) run1 = 1'b1; else run0 = 1'b1;
        A_PULSE: pulse(int'(v[4:3]), ~cur_exp);
        A_LOW:   drive_low(~cur_exp);
        A_HIGH:  sw_req_n = 1'b1;
        default: ;
      endcase
      wait_mon(300);
      @(negedge clk_mon);
      check($sformatf("R%0d row%0d sel", v[11:8], i), sel_out, v[2]);
      check($sformatf("R%0d row%0d lost0", v[11:8], i), lost0, v[1]);
      check($sformatf("R%0d row%0d lost1", v[11:8], i), lost1, v[0]);
      cur_exp = v[2];
    end

    // R1 / R5: reset from reference 1 with the request already low
    mode = 2'b01;
    sw_req_n = 1'b0;
    rst_n = 1'b0;
    wait_mon(5);
    @(negedge clk_mon);
    check("R1 sel in reset", sel_out, 0);
    check("R1 lost0 in reset", lost0, 0);
    check("R1 lost1 in reset", lost1, 0);
    rst_n = 1'b1;
    wait_mon(300);
    @(negedge clk_mon);
    check("R5 low without falling edge", sel_out, 0);
    out_edges = 0;
    wait_mon(30);
    check("R1 output follows clock 0", int'(out_edges >= 9 && out_edges <= 11), 1);
    sw_req_n = 1'b1;
    wait_mon(50);
    check("R10 no runt pulses", runts, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_mon);
    total++;
    bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule